// File: doc/BRIEF.md
# Two-Phase Piezo Drive Pulse Generator

This block produces the pair of square waves that drive one channel of an ultrasonic piezo motor. A fast master clock is divided by a programmed period count to set the switching frequency. Each output pulse has a programmed high time. The second phase is shifted by a quarter period, and the sign of that shift sets the direction of travel. A burst holds a programmed number of periods. When it has run, both outputs go low and the busy flag drops.

Software loads the period, duty and pulse-count bytes and then pulses `start`. These values are captured when `start` is taken. A start with a zero pulse count aborts any running burst at once. Pulling `standby_n` low parks the channel with both outputs low. A clock-doubling option lets a half-rate master clock produce the same output frequency as the full-rate clock.

Top module: `piezo_phase_gen`

## Requirements
- R1: With doubling off, each phase output repeats every P master-clock cycles, where P is `period_cnt` captured at start. The leading phase goes high in the first cycle after the start edge.
- R2: The high time of each pulse is D cycles when `duty_val` D is non-zero. When D is 0 the high time is floor(P/2) cycles. D is expected not to exceed P/2.
- R3: The lagging phase is the leading phase delayed by floor(P/4) cycles. `pulse_hi` bit 6 picks the direction: 0 makes `phase_b` lag `phase_a`, and 1 makes `phase_a` lag `phase_b`.
- R4: The pulse count N is {`pulse_hi`[2:0], `pulse_lo`[7:0]}, from 1 to 2047. `pulse_hi` bits 5:3 have no effect. Exactly N periods are emitted, and `busy` stays high for N·P cycles after the start edge (doubling off). After that, both outputs are low.
- R5: A start with N = 0 makes `busy` and both outputs low from the next cycle on, even in the middle of a burst.
- R6: After reset, and whenever `busy` is low, both phase outputs are low.
- R7: While `standby_n` is low, both outputs and `busy` are low from the next cycle on. A `start` during standby is ignored and is not acted on later.
- R8: When `pulse_hi` bit 7 is set, the period position advances two ticks per master-clock cycle. A period then spans about P/2 cycles, and each high time and the phase offset shrink to match: a window of W ticks lasts ceil(W/2) cycles.
- R9: A non-zero start during a running burst restarts the channel from phase zero with the newly captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_n | input | 1 | Standby, active low; forces the channel idle |
| period_cnt | input | 8 | Period length in master-clock ticks |
| duty_val | input | 8 | High time in ticks; 0 selects half period |
| pulse_hi | input | 8 | Bit 7 doubling, bit 6 direction, bits 2:0 count high bits |
| pulse_lo | input | 8 | Count low byte |
| start | input | 1 | One-cycle strobe that captures the values above |
| phase_a | output | 1 | First phase drive |
| phase_b | output | 1 | Second phase drive |
| busy | output | 1 | High while periods remain in the burst |

## Verification
The bench compares every cycle of each burst against a tick model. A design with an off-by-one in the period wrap or the burst counter would emit one period too many or too few, or would drop `busy` early. The half-period default and the odd-period quarter offset are driven on purpose, so a design that rounds the wrong way shifts an edge by one cycle. Direction swapping, doubling with its ceil-rounded windows, the 2047-count limit with junk in the unused high bits, mid-burst abort, restart and standby are each exercised. A design that decodes the wrong bit, keeps running after a zero write, or remembers a start given during standby leaves an output high where it should be low.

// File: rtl/pz_pkg.sv
package pz_pkg;
    // Field positions inside the pulse-count high byte
    localparam int DBL_BIT = 7;
    localparam int DIR_BIT = 6;
    localparam int BYTE_W  = 8;

    // Which physical output carries the lagging phase
    typedef enum logic {LAG_ON_B = 1'b0, LAG_ON_A = 1'b1} lag_sel_e;
endpackage

// File: rtl/pz_accum.sv
module pz_accum #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             run,
    input  logic             dbl,
    input  logic [PER_W-1:0] period,
    output logic [PER_W-1:0] acc_q,
    output logic [PER_W-1:0] acc_d,
    output logic             wrap
);
    localparam int SW = PER_W + 1;

    logic [SW-1:0] step;
    logic [SW-1:0] sum;
    logic [SW-1:0] per_x;

    always_comb begin
        step  = {{(PER_W-1){1'b0}}, dbl, !dbl};
        sum   = {1'b0, acc_q} + step;
        per_x = {1'b0, period};
        wrap  = run && (sum >= per_x);
        acc_d = acc_q;
        if (clr || load) begin
            acc_d = '0;
        end else if (run) begin
            if (wrap) begin
                acc_d = PER_W'(sum - per_x);
            end else begin
                acc_d = sum[PER_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    AST_ACC_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && period != '0) |-> (acc_q < period)); // R1
endmodule

// File: rtl/pz_burst.sv
module pz_burst #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - ONE)); // R4
endmodule

// File: rtl/pz_window.sv
module pz_window #(
    parameter int PER_W = 8
) (
    input  logic [PER_W-1:0] pos,
    input  logic [PER_W-1:0] offset,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] high,
    output logic             on
);
    localparam int SW = PER_W + 1;

    logic [SW-1:0] shifted;

    always_comb begin
        if (pos >= offset) begin
            shifted = {1'b0, pos} - {1'b0, offset};
        end else begin
            shifted = {1'b0, pos} + {1'b0, period} - {1'b0, offset};
        end
        on = shifted < {1'b0, high};
    end
endmodule

// File: rtl/piezo_phase_gen.sv
module piezo_phase_gen
    import pz_pkg::*;
#(
    parameter int PER_W = 8,
    parameter int CNT_W = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        standby_n,
    input  logic [7:0]  period_cnt,
    input  logic [7:0]  duty_val,
    input  logic [7:0]  pulse_hi,
    input  logic [7:0]  pulse_lo,
    input  logic        start,
    output logic        phase_a,
    output logic        phase_b,
    output logic        busy
);
    localparam int HI_W = CNT_W - BYTE_W;

    typedef struct packed {
        logic [PER_W-1:0] period;
        logic [PER_W-1:0] high;
        logic [PER_W-1:0] quarter;
        lag_sel_e         lag_sel;
        logic             dbl;
        logic             out_a;
        logic             out_b;
    } state_t;

    state_t state_d, state_q;

    logic             req_run, req_stop, clr, load;
    logic [CNT_W-1:0] req_cnt, cnt_q, cnt_d;
    logic [PER_W-1:0] acc_q, acc_d;
    logic             wrap, run;
    logic [PER_W-1:0] win_off [2];
    logic             win_on  [2];

    assign req_cnt  = {pulse_hi[HI_W-1:0], pulse_lo};
    assign req_run  = start && standby_n && (req_cnt != '0);
    assign req_stop = start && standby_n && (req_cnt == '0);
    assign clr      = !standby_n || req_stop;
    assign load     = req_run;
    assign run      = cnt_q != '0;

    pz_accum #(.PER_W(PER_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .load   (load),
        .run    (run),
        .dbl    (state_q.dbl),
        .period (state_q.period),
        .acc_q  (acc_q),
        .acc_d  (acc_d),
        .wrap   (wrap)
    );

    pz_burst #(.CNT_W(CNT_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load     (load),
        .load_val (req_cnt),
        .tick     (wrap),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d)
    );

    // Window 0 is the leading phase, window 1 the lagging phase
    assign win_off[0] = '0;
    assign win_off[1] = state_d.quarter;

    for (genvar gi = 0; gi < 2; gi++) begin : g_win
        pz_window #(.PER_W(PER_W)) u_win (
            .pos    (acc_d),
            .offset (win_off[gi]),
            .period (state_d.period),
            .high   (state_d.high),
            .on     (win_on[gi])
        );
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.period  = period_cnt[PER_W-1:0];
            state_d.high    = (duty_val == '0) ? (period_cnt[PER_W-1:0] >> 1)
                                               : duty_val[PER_W-1:0];
            state_d.quarter = period_cnt[PER_W-1:0] >> 2;
            state_d.lag_sel = lag_sel_e'(pulse_hi[DIR_BIT]);
            state_d.dbl     = pulse_hi[DBL_BIT];
        end
        if (cnt_d == '0) begin
            state_d.out_a = 1'b0;
            state_d.out_b = 1'b0;
        end else if (state_d.lag_sel == LAG_ON_A) begin
            state_d.out_a = win_on[1];
            state_d.out_b = win_on[0];
        end else begin
            state_d.out_a = win_on[0];
            state_d.out_b = win_on[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign phase_a = state_q.out_a;
    assign phase_b = state_q.out_b;
    assign busy    = run;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!phase_a && !phase_b)); // R6
    AST_STANDBY_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |=> (!busy && !phase_a && !phase_b)); // R7
    AST_ZERO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && standby_n && pulse_hi[2:0] == 3'b000 && pulse_lo == 8'h00) |=> !busy); // R5
    AST_START_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && standby_n && req_cnt != '0) |=> (busy && (phase_a || phase_b))); // R1
endmodule

// File: tb/piezo_phase_gen_test.sv
`timescale 1ns/1ps
module piezo_phase_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby_n = 1'b1;
    logic [7:0] period_cnt = 8'd0;
    logic [7:0] duty_val = 8'd0;
    logic [7:0] pulse_hi = 8'd0;
    logic [7:0] pulse_lo = 8'd0;
    logic       start = 1'b0;
    logic       phase_a, phase_b, busy;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    int m_acc, m_rem, m_p, m_h, m_q, m_step;
    bit m_dir;

    always #10 clk = ~clk;

    piezo_phase_gen uut (
        .clk(clk), .rst_n(rst_n), .standby_n(standby_n),
        .period_cnt(period_cnt), .duty_val(duty_val),
        .pulse_hi(pulse_hi), .pulse_lo(pulse_lo), .start(start),
        .phase_a(phase_a), .phase_b(phase_b), .busy(busy)
    );

    task automatic check_now(input string tag);
        bit eb, lead, lag, ea, ebb;
        int sh;
        eb   = m_rem > 0;
        lead = m_acc < m_h;
        sh   = (m_acc >= m_q) ? m_acc - m_q : m_acc + m_p - m_q;
        lag  = sh < m_h;
        ea   = eb && (m_dir ? lag : lead);
        ebb  = eb && (m_dir ? lead : lag);
        n_checks++;
        if (phase_a !== ea || phase_b !== ebb || busy !== eb) begin
            n_fail++;
            $display("FAIL %s: got a=%b b=%b busy=%b expected a=%b b=%b busy=%b",
                     tag, phase_a, phase_b, busy, ea, ebb, eb);
        end
    endtask

    task automatic step_model();
        int nx;
        if (m_rem > 0) begin
            nx = m_acc + m_step;
            if (nx >= m_p) begin
                nx = nx - m_p;
                m_rem--;
            end
            m_acc = nx;
        end
    endtask

    // called at a falling edge; checks n cycles, ending on a falling edge
    task automatic check_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            check_now(tag);
            step_model();
            @(negedge clk);
        end
    endtask

    // called at a falling edge; returns at the falling edge after capture
    task automatic kick(input int p, input int d, input int n,
                        input bit dir, input bit dbl, input logic [2:0] junk);
        period_cnt = p[7:0];
        duty_val   = d[7:0];
        pulse_hi   = {dbl, dir, junk, n[10:8]};
        pulse_lo   = n[7:0];
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (standby_n) begin
            m_rem = n;
            if (n != 0) begin
                m_acc  = 0;
                m_p    = p;
                m_h    = (d == 0) ? p / 2 : d;
                m_q    = p / 4;
                m_dir  = dir;
                m_step = dbl ? 2 : 1;
            end
        end
    endtask

    task automatic t_reset();
        m_rem = 0; m_acc = 0; m_p = 1; m_h = 0; m_q = 0; m_dir = 0; m_step = 1;
        check_cycles(2, "R6 reset");
    endtask

    task automatic t_basic();
        kick(20, 0, 3, 1'b0, 1'b0, 3'b000);
        check_cycles(3 * 20 + 3, "R1 R2 R3 R4 basic");
    endtask

    task automatic t_dir_duty();
        kick(22, 3, 2, 1'b1, 1'b0, 3'b000);
        check_cycles(2 * 22 + 3, "R2 R3 dir=1 duty=3");
        kick(133, 1, 1, 1'b0, 1'b0, 3'b000);
        check_cycles(133 + 2, "R2 duty=1 p=133");
        kick(133, 66, 2, 1'b1, 1'b0, 3'b000);
        check_cycles(266 + 2, "R2 R3 duty=66 p=133");
    endtask

    task automatic t_odd_period();
        kick(23, 0, 2, 1'b0, 1'b0, 3'b000);
        check_cycles(46 + 2, "R2 R3 odd period");
    endtask

    task automatic t_double();
        kick(24, 0, 3, 1'b0, 1'b1, 3'b000);
        check_cycles(3 * 12 + 3, "R8 doubling even");
        kick(111, 5, 2, 1'b1, 1'b1, 3'b000);
        check_cycles(115, "R8 doubling odd");
    endtask

    task automatic t_stop();
        kick(20, 0, 5, 1'b0, 1'b0, 3'b000);
        check_cycles(27, "R4 before stop");
        kick(20, 0, 0, 1'b0, 1'b0, 3'b000);
        check_cycles(25, "R5 zero stop");
    endtask

    task automatic t_restart();
        kick(16, 0, 4, 1'b0, 1'b0, 3'b000);
        check_cycles(21, "R9 first burst");
        kick(12, 4, 2, 1'b1, 1'b0, 3'b000);
        check_cycles(24 + 3, "R9 restart");
    endtask

    task automatic t_standby();
        kick(20, 0, 6, 1'b0, 1'b0, 3'b000);
        check_cycles(13, "R7 before standby");
        standby_n = 1'b0;
        @(negedge clk);
        m_rem = 0;
        check_cycles(3, "R7 standby");
        kick(20, 0, 6, 1'b0, 1'b0, 3'b000);
        check_cycles(5, "R7 start ignored");
        standby_n = 1'b1;
        @(negedge clk);
        check_cycles(25, "R7 not remembered");
    endtask

    task automatic t_max_count();
        kick(4, 0, 2047, 1'b0, 1'b0, 3'b000);
        check_cycles(2047 * 4 + 3, "R4 max count");
        kick(10, 0, 1, 1'b0, 1'b0, 3'b111);
        check_cycles(10 + 3, "R4 bits 5:3 ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_dir_duty();
        t_odd_period();
        t_double();
        t_stop();
        t_restart();
        t_standby();
        t_max_count();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule